// File: doc/BRIEF.md
# Windowed Rolling-Shutter Readout Sequencer

This block produces the control timing needed to read a rectangular region out of a rolling-shutter pixel array, one pixel per system clock. Software sets a start column, start row, width, height, integration length and blanking length on static inputs, then pulses a start request. The sequencer first brackets the exposure with a begin strobe and an end strobe. It then walks the window row by row. Each row opens with a row-clock pulse and a blanking interval in which no pixel is valid. The row's pixels then follow back to back, with a valid strobe and the current row and column address.

The window is made legal before use. The start column is forced even. A start outside the array is pulled back inside it. Width and height are clipped so that the window ends at the array edge at the latest. All settings are captured at the moment the start request is accepted, so later writes cannot disturb the frame in progress. The whole frame takes 2 + L + H × (B + W) cycles, where L and B are the integration and blanking counts, each raised to at least 1, and H and W are the clipped window height and width. The default array is 1280 × 1024 with 24-bit counts.

Top module: `winseq_top`

## Requirements
- R1: A start request is accepted only while idle. One cycle after acceptance `integ_begin` is high for exactly one cycle. It is followed by L = max(integration count, 1) quiet cycles, and then `integ_end` is high for exactly one cycle.
- R2: The cycle after `integ_end`, and the cycle after each row's last pixel except the final one, begins a row. `row_clk` is high for only that one cycle of the row. `row_first` is high together with `row_clk` for the first window row only.
- R3: Every row opens with B = max(blanking count, 1) cycles in which `pix_valid` is low. `row_clk` lies in the first of these cycles.
- R4: After blanking, `pix_valid` is high for W consecutive cycles. `pix_col` counts up by one each cycle from the effective start column. `pix_col` and `pix_row` read zero while `pix_valid` is low.
- R5: The effective start column is the requested one with bit 0 cleared. If that value exceeds COLS−2, COLS−2 is used instead.
- R6: The effective start row is min(requested row, ROWS−1). W = min(max(width, 1), COLS − start column) and H = min(max(height, 1), ROWS − start row). No valid pixel lies outside the array.
- R7: `pix_row` equals the effective start row plus the index of the current window row, for rows 0 to H−1.
- R8: `busy` is high from the cycle showing `integ_begin` through the cycle of the last pixel. `frame_done` is high for exactly the one cycle after that, with `busy` low.
- R9: All settings are captured at acceptance. Changes to the setting inputs during a frame, and start requests while busy, affect neither that frame nor the state that follows it.
- R10: While the synchronous active-high `rst` is sampled high, the block returns to idle. All outputs read zero in the next cycle.
- R11: A frame occupies exactly 2 + L + H × (B + W) busy cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one pixel per cycle |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | Frame start request, taken only when idle |
| cfg_col0 | input | $clog2(COLS) | Requested start column |
| cfg_row0 | input | $clog2(ROWS) | Requested start row |
| cfg_width | input | $clog2(COLS)+1 | Requested window width in pixels |
| cfg_height | input | $clog2(ROWS)+1 | Requested window height in rows |
| cfg_integ | input | CNT_W | Integration length in clocks |
| cfg_blank | input | CNT_W | Row blanking length in clocks |
| integ_begin | output | 1 | One-cycle exposure start strobe |
| integ_end | output | 1 | One-cycle exposure stop strobe |
| row_clk | output | 1 | One-cycle pulse at the start of each row |
| row_first | output | 1 | Marks the first row's pulse of a frame |
| pix_valid | output | 1 | Current cycle carries a window pixel |
| pix_col | output | $clog2(COLS) | Column of the current pixel |
| pix_row | output | $clog2(ROWS) | Row of the current pixel |
| busy | output | 1 | Frame in progress |
| frame_done | output | 1 | One-cycle pulse after the last pixel |

## Verification
The bench builds the block with a 12 × 6 array and 8-bit counts. Both dimensions are deliberately not powers of two, so that the 4-bit column and 3-bit row inputs can address past the edge. This exercises start clamping, odd-column rounding and width and height clipping on all three sides. It sweeps every start column, with zero, partial, exact and oversized widths and heights. It also sweeps integration and blanking counts from 0 to 4. Every output is compared against arithmetic expectations on every cycle of every frame. Further runs cover setting changes and start requests injected mid-frame, and a reset applied mid-frame.

// File: rtl/winseq_pkg.sv
package winseq_pkg;

    // Sequencer phases, in the order a frame visits them
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_INT_ON  = 3'd1,
        ST_INTEG   = 3'd2,
        ST_INT_OFF = 3'd3,
        ST_BLANK   = 3'd4,
        ST_ACTIVE  = 3'd5
    } seq_state_e;

endpackage

// File: rtl/winseq_window.sv
// Makes a requested window legal: even start column, start inside the array,
// extent clipped to the array edge, zero sizes raised to one.
module winseq_window #(
    parameter int COLS = 1280,
    parameter int ROWS = 1024,
    localparam int COL_W = $clog2(COLS),
    localparam int ROW_W = $clog2(ROWS),
    localparam int CW1   = COL_W + 1,
    localparam int RW1   = ROW_W + 1
) (
    input  logic [COL_W-1:0] req_col0,
    input  logic [ROW_W-1:0] req_row0,
    input  logic [CW1-1:0]   req_width,
    input  logic [RW1-1:0]   req_height,
    output logic [COL_W-1:0] win_col0,
    output logic [ROW_W-1:0] win_row0,
    output logic [CW1-1:0]   win_width,
    output logic [RW1-1:0]   win_height
);

    int c0_v, w_v, r0_v, h_v;

    always_comb begin
        // column start: even, and at most COLS-2
        c0_v = int'(req_col0) & ~1;
        if (c0_v > COLS - 2) c0_v = COLS - 2;
        w_v = int'(req_width);
        if (w_v == 0) w_v = 1;
        if (w_v > COLS - c0_v) w_v = COLS - c0_v;

        // row start: any row, at most ROWS-1
        r0_v = int'(req_row0);
        if (r0_v > ROWS - 1) r0_v = ROWS - 1;
        h_v = int'(req_height);
        if (h_v == 0) h_v = 1;
        if (h_v > ROWS - r0_v) h_v = ROWS - r0_v;

        win_col0   = COL_W'(c0_v);
        win_width  = CW1'(w_v);
        win_row0   = ROW_W'(r0_v);
        win_height = RW1'(h_v);
    end

endmodule

// File: rtl/winseq_ctrl.sv
// Frame sequencer: exposure bracket, then per row a blanking phase and an
// active phase. All settings are captured when the start request is taken.
module winseq_ctrl
    import winseq_pkg::*;
#(
    parameter int COLS  = 1280,
    parameter int ROWS  = 1024,
    parameter int CNT_W = 24,
    localparam int COL_W = $clog2(COLS),
    localparam int ROW_W = $clog2(ROWS),
    localparam int CW1   = COL_W + 1,
    localparam int RW1   = ROW_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic [COL_W-1:0] win_col0,
    input  logic [ROW_W-1:0] win_row0,
    input  logic [CW1-1:0]   win_width,
    input  logic [RW1-1:0]   win_height,
    input  logic [CNT_W-1:0] integ_len,
    input  logic [CNT_W-1:0] blank_len,
    output logic             integ_begin,
    output logic             integ_end,
    output logic             row_clk,
    output logic             row_first,
    output logic             pix_valid,
    output logic [COL_W-1:0] pix_col,
    output logic [ROW_W-1:0] pix_row,
    output logic             busy,
    output logic             frame_done
);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;       // cycles left in integration or blanking
        logic [CW1-1:0]   px;        // pixel index within the row
        logic [RW1-1:0]   rix;       // row index within the window
        logic [COL_W-1:0] col0;
        logic [ROW_W-1:0] row0;
        logic [CW1-1:0]   wid;
        logic [RW1-1:0]   hgt;
        logic [CNT_W-1:0] blank_m1;
        logic             done;
    } seq_regs_t;

    seq_regs_t r_d, r_q;
    logic [CNT_W-1:0] integ_m1_w;
    logic [CNT_W-1:0] blank_m1_w;
    logic             last_px;
    logic             last_row;

    always_comb begin
        integ_m1_w = (integ_len == '0) ? '0 : integ_len - CNT_W'(1);
        blank_m1_w = (blank_len == '0) ? '0 : blank_len - CNT_W'(1);
        last_px    = (r_q.px == r_q.wid - CW1'(1));
        last_row   = (r_q.rix == r_q.hgt - RW1'(1));

        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_req) begin
                    r_d.st       = ST_INT_ON;
                    r_d.cnt      = integ_m1_w;
                    r_d.col0     = win_col0;
                    r_d.row0     = win_row0;
                    r_d.wid      = win_width;
                    r_d.hgt      = win_height;
                    r_d.blank_m1 = blank_m1_w;
                end
            end
            ST_INT_ON: r_d.st = ST_INTEG;
            ST_INTEG: begin
                if (r_q.cnt == '0) r_d.st = ST_INT_OFF;
                else               r_d.cnt = r_q.cnt - CNT_W'(1);
            end
            ST_INT_OFF: begin
                r_d.st  = ST_BLANK;
                r_d.cnt = r_q.blank_m1;
                r_d.rix = '0;
            end
            ST_BLANK: begin
                if (r_q.cnt == '0) begin
                    r_d.st = ST_ACTIVE;
                    r_d.px = '0;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_ACTIVE: begin
                if (!last_px) begin
                    r_d.px = r_q.px + CW1'(1);
                end else if (last_row) begin
                    r_d.st   = ST_IDLE;
                    r_d.done = 1'b1;
                end else begin
                    r_d.st  = ST_BLANK;
                    r_d.cnt = r_q.blank_m1;
                    r_d.rix = r_q.rix + RW1'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    always_comb begin
        integ_begin = (r_q.st == ST_INT_ON);
        integ_end   = (r_q.st == ST_INT_OFF);
        row_clk     = (r_q.st == ST_BLANK) && (r_q.cnt == r_q.blank_m1);
        row_first   = row_clk && (r_q.rix == '0);
        pix_valid   = (r_q.st == ST_ACTIVE);
        pix_col     = pix_valid ? COL_W'(CW1'(r_q.col0) + r_q.px) : '0;
        pix_row     = pix_valid ? ROW_W'(RW1'(r_q.row0) + r_q.rix) : '0;
        busy        = (r_q.st != ST_IDLE);
        frame_done  = r_q.done;
    end

    // R9: captured window and blanking stay fixed for the whole frame
    p_cfg_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(r_q.col0) && $stable(r_q.row0) &&
                                   $stable(r_q.wid) && $stable(r_q.hgt) &&
                                   $stable(r_q.blank_m1)));

    // R1: exposure begin always leads into the counted integration window
    p_integ_seq_r1: assert property (@(posedge clk) disable iff (rst)
        integ_begin |=> (r_q.st == ST_INTEG));

    // R2: a row pulse is never repeated in the next cycle
    p_row_clk_single_r2: assert property (@(posedge clk) disable iff (rst)
        row_clk |=> !row_clk);

endmodule

// File: rtl/winseq_top.sv
module winseq_top #(
    parameter int COLS  = 1280,
    parameter int ROWS  = 1024,
    parameter int CNT_W = 24,
    localparam int COL_W = $clog2(COLS),
    localparam int ROW_W = $clog2(ROWS),
    localparam int CW1   = COL_W + 1,
    localparam int RW1   = ROW_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic [COL_W-1:0] cfg_col0,
    input  logic [ROW_W-1:0] cfg_row0,
    input  logic [CW1-1:0]   cfg_width,
    input  logic [RW1-1:0]   cfg_height,
    input  logic [CNT_W-1:0] cfg_integ,
    input  logic [CNT_W-1:0] cfg_blank,
    output logic             integ_begin,
    output logic             integ_end,
    output logic             row_clk,
    output logic             row_first,
    output logic             pix_valid,
    output logic [COL_W-1:0] pix_col,
    output logic [ROW_W-1:0] pix_row,
    output logic             busy,
    output logic             frame_done
);

    logic [COL_W-1:0] win_col0;
    logic [ROW_W-1:0] win_row0;
    logic [CW1-1:0]   win_width;
    logic [RW1-1:0]   win_height;

    winseq_window #(.COLS(COLS), .ROWS(ROWS)) u_window (
        .req_col0   (cfg_col0),
        .req_row0   (cfg_row0),
        .req_width  (cfg_width),
        .req_height (cfg_height),
        .win_col0   (win_col0),
        .win_row0   (win_row0),
        .win_width  (win_width),
        .win_height (win_height)
    );

    winseq_ctrl #(.COLS(COLS), .ROWS(ROWS), .CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_req   (start_req),
        .win_col0    (win_col0),
        .win_row0    (win_row0),
        .win_width   (win_width),
        .win_height  (win_height),
        .integ_len   (cfg_integ),
        .blank_len   (cfg_blank),
        .integ_begin (integ_begin),
        .integ_end   (integ_end),
        .row_clk     (row_clk),
        .row_first   (row_first),
        .pix_valid   (pix_valid),
        .pix_col     (pix_col),
        .pix_row     (pix_row),
        .busy        (busy),
        .frame_done  (frame_done)
    );

    // R3: strobes from different phases never coincide
    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({integ_begin, integ_end, row_clk, pix_valid}));

    // R4: consecutive valid pixels step the column by one
    p_col_step_r4: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && $past(pix_valid)) |-> (pix_col == $past(pix_col) + COL_W'(1)));

    // R5: each row's first pixel sits on an even column
    p_even_start_r5: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !$past(pix_valid)) |-> (pix_col[0] == 1'b0));

    // R6: no valid pixel outside the array
    p_in_array_r6: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> ((int'(pix_col) < COLS) && (int'(pix_row) < ROWS)));

    // R8: completion pulse follows the end of busy
    p_done_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
        frame_done |-> (!busy && $past(busy)));

    // R2: the first-row marker only accompanies a row pulse
    p_first_with_clk_r2: assert property (@(posedge clk) disable iff (rst)
        row_first |-> row_clk);

endmodule

// File: tb/tb_winseq_top.sv
module tb_winseq_top;

    localparam int C   = 12;
    localparam int R   = 6;
    localparam int CW  = 8;
    localparam int COL_W = $clog2(C);
    localparam int ROW_W = $clog2(R);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_req = 1'b0;
    logic [COL_W-1:0] cfg_col0 = '0;
    logic [ROW_W-1:0] cfg_row0 = '0;
    logic [COL_W:0]   cfg_width = '0;
    logic [ROW_W:0]   cfg_height = '0;
    logic [CW-1:0]    cfg_integ = '0;
    logic [CW-1:0]    cfg_blank = '0;
    logic             integ_begin, integ_end, row_clk, row_first, pix_valid;
    logic [COL_W-1:0] pix_col;
    logic [ROW_W-1:0] pix_row;
    logic             busy, frame_done;

    int vectors = 0;
    int miscompares = 0;
    int cycles = 0;

    winseq_top #(.COLS(C), .ROWS(R), .CNT_W(CW)) dut (
        .clk(clk), .rst(rst), .start_req(start_req),
        .cfg_col0(cfg_col0), .cfg_row0(cfg_row0),
        .cfg_width(cfg_width), .cfg_height(cfg_height),
        .cfg_integ(cfg_integ), .cfg_blank(cfg_blank),
        .integ_begin(integ_begin), .integ_end(integ_end),
        .row_clk(row_clk), .row_first(row_first),
        .pix_valid(pix_valid), .pix_col(pix_col), .pix_row(pix_row),
        .busy(busy), .frame_done(frame_done)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            miscompares = miscompares + 1;
            $display("FAIL watchdog R11: actual=%0d cycles expected=below 190000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    task automatic chk(input string tag, input int t, input int act, input int exp);
        vectors = vectors + 1;
        if (act != exp) begin
            miscompares = miscompares + 1;
            $display("FAIL %s t=%0d actual=%0d expected=%0d", tag, t, act, exp);
        end
    endtask

    task automatic set_cfg(input int c0, input int r0, input int w, input int h,
                           input int ig, input int bl);
        cfg_col0   = COL_W'(c0);
        cfg_row0   = ROW_W'(r0);
        cfg_width  = (COL_W+1)'(w);
        cfg_height = (ROW_W+1)'(h);
        cfg_integ  = CW'(ig);
        cfg_blank  = CW'(bl);
    endtask

    // Runs one frame and compares every output on every cycle.
    task automatic run_frame(input int c0, input int r0, input int w, input int h,
                             input int ig, input int bl, input bit disturb);
        int ec0, er0, ew, eh, el, eb, total;
        ec0 = c0 & ~1;                       // R5
        if (ec0 > C - 2) ec0 = C - 2;
        ew = (w == 0) ? 1 : w;               // R6
        if (ew > C - ec0) ew = C - ec0;
        er0 = (r0 > R - 1) ? R - 1 : r0;
        eh = (h == 0) ? 1 : h;
        if (eh > R - er0) eh = R - er0;
        el = (ig == 0) ? 1 : ig;
        eb = (bl == 0) ? 1 : bl;
        total = 2 + el + eh * (eb + ew);     // R11

        @(negedge clk);
        set_cfg(c0, r0, w, h, ig, bl);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        for (int t = 0; t <= total; t++) begin
            int xb, xe, xrc, xrf, xv, xcol, xrow, tp, rr, pp;
            xb = (t == 0); xe = (t == el + 1);
            xrc = 0; xrf = 0; xv = 0; xcol = 0; xrow = 0;
            if (t >= el + 2 && t < total) begin
                tp = t - el - 2;
                rr = tp / (eb + ew);
                pp = tp % (eb + ew);
                xrc = (pp == 0);
                xrf = xrc && (rr == 0);
                xv = (pp >= eb);
                if (xv != 0) begin
                    xcol = ec0 + pp - eb;
                    xrow = er0 + rr;
                end
            end
            chk("R1 integ_begin", t, int'(integ_begin), xb);
            chk("R1 integ_end", t, int'(integ_end), xe);
            chk("R2 row_clk", t, int'(row_clk), xrc);
            chk("R2 row_first", t, int'(row_first), xrf);
            chk("R3 R4 pix_valid", t, int'(pix_valid), xv);
            chk("R4 R5 R6 pix_col", t, int'(pix_col), xcol);
            chk("R7 R6 pix_row", t, int'(pix_row), xrow);
            chk("R8 R11 busy", t, int'(busy), (t < total) ? 1 : 0);
            chk("R8 frame_done", t, int'(frame_done), (t == total) ? 1 : 0);
            if (disturb && t == 3) begin
                set_cfg(1, 0, 31, 15, 9, 9);   // R9 mid-frame write and start
                start_req = 1'b1;
            end
            if (disturb && t == 4) start_req = 1'b0;
            if (t < total) @(negedge clk);
        end
        @(negedge clk);
        chk("R8 R9 busy after done", total + 1, int'(busy), 0);
        chk("R8 frame_done single", total + 1, int'(frame_done), 0);
    endtask

    task automatic chk_quiet(input string tag);
        chk(tag, -1, int'(integ_begin), 0);
        chk(tag, -1, int'(integ_end), 0);
        chk(tag, -1, int'(row_clk), 0);
        chk(tag, -1, int'(row_first), 0);
        chk(tag, -1, int'(pix_valid), 0);
        chk(tag, -1, int'(pix_col), 0);
        chk(tag, -1, int'(pix_row), 0);
        chk(tag, -1, int'(busy), 0);
        chk(tag, -1, int'(frame_done), 0);
    endtask

    initial begin
        int wl[4];
        int rl[4];
        int hl[3];
        wl = '{0, 5, 12, 31};
        rl = '{0, 3, 5, 7};
        hl = '{0, 2, 15};

        repeat (3) @(negedge clk);
        chk_quiet("R10 reset state");
        rst = 1'b0;
        @(negedge clk);
        chk_quiet("R10 idle after reset");

        // R5 R6 R7: window sweep over every start column
        for (int c0 = 0; c0 < 16; c0++)
            for (int wi = 0; wi < 4; wi++)
                for (int ri = 0; ri < 4; ri++)
                    for (int hi = 0; hi < 3; hi++)
                        run_frame(c0, rl[ri], wl[wi], hl[hi], 1, 2, 1'b0);

        // R1 R3 R11: integration and blanking lengths incl. zero
        for (int ig = 0; ig < 5; ig++)
            for (int bl = 0; bl < 5; bl++)
                run_frame(3, 1, 4, 2, ig, bl, 1'b0);

        // R9: writes and start requests during a frame
        run_frame(4, 2, 5, 3, 3, 2, 1'b1);
        run_frame(11, 5, 0, 0, 0, 0, 1'b1);

        // R10: reset in the middle of a frame
        @(negedge clk);
        set_cfg(2, 1, 6, 3, 4, 3);
        start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        repeat (9) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk_quiet("R10 mid-frame reset");
        rst = 1'b0;
        @(negedge clk);
        chk_quiet("R10 stays idle");

        run_frame(0, 0, 12, 6, 2, 1, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule